// File: doc/BRIEF.md
# Time-of-Day Keeper with Run/Stop/Load Control

This block keeps the time of day in three binary registers, one each for hours, minutes and seconds. A small control state machine owns them. A tick that lasts one clock cycle and arrives once per second moves the time forward. Each carry passes from seconds to minutes and from minutes to hours. A parameter sets the hour range to either a 24-hour or a 12-hour dial.

The surrounding logic starts and halts the count with a run/stop level. It can set a new time at any moment by pulsing a load strobe while it presents a reference time. The block also reports its current control mode as a 2-bit code. The owner of the block produces the tick from the 1 Hz source. That same owner drives any display or alarm.

Top module: `tod_keeper`

## Requirements
- R1: `mode` reports the registered control state: 0 = cleared, 1 = running, 2 = halted, 3 = loading. It changes only at a rising clock edge.
- R2: Each rising edge with `rst` high sets the time to 00:00:00 and `mode` to 0. Both stay there for as long as `rst` stays high.
- R3: When neither `rst` nor `load_req` is high, a state of 0, 1 or 2 moves on the edge to 1 if `run_en` is high and to 2 if it is low.
- R4: When `mode` is 1 before an edge and `sec_tick` is high, seconds go up by exactly one on that edge. Minutes and hours hold when seconds were below 59.
- R5: A counted tick at second 59 sets seconds to 0 and adds one to minutes.
- R6: A counted tick at minute 59 and second 59 sets minutes and seconds to 0 and moves the hours on by one.
- R7: With `HOURS_24 = 1`, hours run from 0 to 23, and 23:59:59 followed by a counted tick becomes 00:00:00.
- R8: With `HOURS_24 = 0`, an hour step from 12 gives 1 and a step from any other value adds one. So 12:59:59 becomes 01:00:00, and hour 0, which is left after reset, steps to 1.
- R9: A tick has no effect on the time when `mode` is 0, 2 or 3 before the edge.
- R10: `load_req` high without `rst` copies `ref_hh:ref_mm:ref_ss` into the time on the next edge and sets `mode` to 3. The following edge sets `mode` to 1 whatever `run_en` is, unless `load_req` is high again.
- R11: Priority is reset over load, and load over tick. A tick in the same cycle as a load is discarded, and the loaded time is not advanced by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse per second |
| run_en | input | 1 | High to run, low to halt |
| load_req | input | 1 | Strobe to load the reference time |
| ref_hh | input | 5 | Reference hours |
| ref_mm | input | 6 | Reference minutes |
| ref_ss | input | 6 | Reference seconds |
| hh | output | 5 | Current hours |
| mm | output | 6 | Current minutes |
| ss | output | 6 | Current seconds |
| mode | output | 2 | Current control state code |

## Verification
The hour-range and wrap checks assume that every loaded reference time is valid for the chosen dial. For a 24-hour dial that means hours 0 to 23. For a 12-hour dial it means hours 1 to 12. In both cases minutes and seconds lie between 0 and 59. The stimulus builds each reference from these ranges by taking a modulo of a random value. It uses a separate reference for each dial instance, so no out-of-range value ever reaches a register. Ticks, loads, resets and run/stop changes are otherwise unconstrained and may coincide in any cycle.

// File: rtl/tod_keeper.sv
module tod_keeper #(
  parameter bit HOURS_24 = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic       run_en,
  input  logic       load_req,
  input  logic [4:0] ref_hh,
  input  logic [5:0] ref_mm,
  input  logic [5:0] ref_ss,
  output logic [4:0] hh,
  output logic [5:0] mm,
  output logic [5:0] ss,
  output logic [1:0] mode
);

  localparam logic [4:0] H_TOP = HOURS_24 ? 5'd23 : 5'd12;
  localparam logic [4:0] H_BOT = HOURS_24 ? 5'd0 : 5'd1;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_RUN   = 2'd1,
    ST_HALT  = 2'd2,
    ST_LOAD  = 2'd3
  } state_t;

  state_t     st_q;
  logic [4:0] hh_q;
  logic [5:0] mm_q, ss_q;

  wire adv    = (st_q == ST_RUN) && sec_tick;
  wire s_last = (ss_q == 6'd59);
  wire m_last = (mm_q == 6'd59);
  wire [4:0] hh_step = (hh_q == H_TOP) ? H_BOT : hh_q + 5'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_CLEAR;
      hh_q <= '0;
      mm_q <= '0;
      ss_q <= '0;
    end else if (load_req) begin
      st_q <= ST_LOAD;
      hh_q <= ref_hh;
      mm_q <= ref_mm;
      ss_q <= ref_ss;
    end else begin
      st_q <= (st_q == ST_LOAD || run_en) ? ST_RUN : ST_HALT;
      if (adv) begin
        ss_q <= s_last ? 6'd0 : ss_q + 6'd1;
        if (s_last) begin
          mm_q <= m_last ? 6'd0 : mm_q + 6'd1;
          if (m_last) hh_q <= hh_step;
        end
      end
    end
  end

  assign hh   = hh_q;
  assign mm   = mm_q;
  assign ss   = ss_q;
  assign mode = st_q;

  // R2
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (hh == 5'd0 && mm == 6'd0 && ss == 6'd0 && mode == 2'd0));

  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && sec_tick && !load_req && ss != 6'd59)
    |=> (ss == $past(ss) + 6'd1 && $stable(mm) && $stable(hh)));

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && sec_tick && !load_req && ss == 6'd59 && mm != 6'd59)
    |=> (ss == 6'd0 && mm == $past(mm) + 6'd1 && $stable(hh)));

  // R6
  min_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && sec_tick && !load_req && ss == 6'd59 && mm == 6'd59)
    |=> (ss == 6'd0 && mm == 6'd0 && hh != $past(hh)));

  // R7
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    !load_req |=> (hh <= H_TOP));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd1 && !load_req) |=> ($stable(ss) && $stable(mm) && $stable(hh)));

  // R10
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (hh == $past(ref_hh) && mm == $past(ref_mm)
                  && ss == $past(ref_ss) && mode == 2'd3));

  // R10
  load_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !load_req) |=> (mode == 2'd1));

endmodule

// File: tb/test_tod_keeper.sv
module test_tod_keeper;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tick, run, ld;
  logic [4:0] rh24, rh12;
  logic [5:0] rm, rs;
  logic [4:0] h24, h12;
  logic [5:0] m24, s24, m12, s12;
  logic [1:0] md24, md12;
  logic [18:0] exp24, exp12;
  int checks = 0, errors = 0;

  tod_keeper #(.HOURS_24(1'b1)) i_tod_keeper (
    .clk(clk), .rst(rst), .sec_tick(tick), .run_en(run), .load_req(ld),
    .ref_hh(rh24), .ref_mm(rm), .ref_ss(rs),
    .hh(h24), .mm(m24), .ss(s24), .mode(md24));

  tod_keeper #(.HOURS_24(1'b0)) i_tod_keeper_12 (
    .clk(clk), .rst(rst), .sec_tick(tick), .run_en(run), .load_req(ld),
    .ref_hh(rh12), .ref_mm(rm), .ref_ss(rs),
    .hh(h12), .mm(m12), .ss(s12), .mode(md12));

  function automatic logic [18:0] model(input bit is24, input logic [18:0] cur,
      input logic r, t, rn, l, input logic [16:0] rf);
    logic [1:0] st; logic [4:0] h; logic [5:0] m, s;
    {st, h, m, s} = cur;
    if (r) return 19'd0;
    if (l) return {2'd3, rf};
    if (st == 2'd1 && t) begin
      if (s == 6'd59) begin
        s = 6'd0;
        if (m == 6'd59) begin
          m = 6'd0;
          if (is24) h = (h == 5'd23) ? 5'd0 : h + 5'd1;
          else      h = (h == 5'd12) ? 5'd1 : h + 5'd1;
        end else m = m + 6'd1;
      end else s = s + 6'd1;
    end
    st = (st == 2'd3 || rn) ? 2'd1 : 2'd2;
    return {st, h, m, s};
  endfunction

  task automatic step(input logic r, t, rn, l, input string tag);
    @(negedge clk);
    rst = r; tick = t; run = rn; ld = l;
    @(posedge clk);
    exp24 = model(1'b1, exp24, r, t, rn, l, {rh24, rm, rs});
    exp12 = model(1'b0, exp12, r, t, rn, l, {rh12, rm, rs});
    #1;
    checks += 2;
    if ({md24, h24, m24, s24} !== exp24) begin
      errors++;
      $display("FAIL %s 24h: got %h expected %h", tag, {md24, h24, m24, s24}, exp24);
    end
    if ({md12, h12, m12, s12} !== exp12) begin
      errors++;
      $display("FAIL %s 12h: got %h expected %h", tag, {md12, h12, m12, s12}, exp12);
    end
  endtask

  task automatic set_ref(input logic [4:0] a24, a12, input logic [5:0] m, s);
    @(negedge clk);
    rh24 = a24; rh12 = a12; rm = m; rs = s;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20150207));
    rst = 1'b1; tick = 1'b0; run = 1'b0; ld = 1'b0;
    rh24 = '0; rh12 = 5'd1; rm = '0; rs = '0;
    exp24 = '0; exp12 = '0;
    // R1 R2: reset held with ticks and loads present
    step(1, 1, 1, 1, "R2");
    step(1, 1, 1, 0, "R2");
    step(1, 0, 0, 0, "R1");
    // R3: run/stop selection
    step(0, 0, 1, 0, "R3");
    step(0, 1, 1, 0, "R4");
    step(0, 0, 0, 0, "R3");
    // R9: halted ignores ticks
    step(0, 1, 0, 0, "R9");
    step(0, 1, 0, 0, "R9");
    // R10 R7 R8: load near rollover
    set_ref(5'd23, 5'd12, 6'd59, 6'd58);
    step(0, 0, 0, 1, "R10");
    step(0, 1, 0, 0, "R10");
    step(0, 1, 1, 0, "R4");
    step(0, 1, 1, 0, "R7 R8");
    step(0, 1, 1, 0, "R4");
    // R5 minute carry
    set_ref(5'd10, 5'd10, 6'd58, 6'd59);
    step(0, 0, 1, 1, "R10");
    step(0, 0, 1, 0, "R10");
    step(0, 1, 1, 0, "R5");
    // R6 hour carry
    set_ref(5'd10, 5'd10, 6'd59, 6'd59);
    step(0, 0, 1, 1, "R10");
    step(0, 0, 1, 0, "R10");
    step(0, 1, 1, 0, "R6");
    // R11: load beats tick, reset beats load
    set_ref(5'd5, 5'd5, 6'd5, 6'd5);
    step(0, 1, 1, 1, "R11");
    step(0, 1, 1, 1, "R11");
    step(1, 1, 1, 1, "R11");
    // R8: 12h hour 0 after reset steps to 1
    step(0, 0, 1, 0, "R3");
    for (int i = 0; i < 3601; i++) step(0, 1, 1, 0, "R8");
    // mixed random traffic
    for (int i = 0; i < 6000; i++) begin
      logic r, t, rn, l;
      r  = ($urandom % 200) == 0;
      l  = ($urandom % 30) == 0;
      t  = ($urandom % 10) < 7;
      rn = ($urandom % 10) != 0;
      if (l) set_ref(5'($urandom % 24), 5'($urandom % 12 + 1),
                     6'($urandom % 60), 6'($urandom % 60));
      step(r, t, rn, l, "MIX");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule